// File: doc/BRIEF.md
# Strobe-Clocked Serial Register Programming Slave

This block lets an external host read and write a byte-wide internal register file over three wires: a serial data input, a strobe that acts as the shift clock, and a serial data output for read-back. Both host lines are brought into the system clock domain through a short synchronizer chain. Edge detection on the synchronized strobe then turns each strobe pulse into one event.

A frame opens with a START pulse. In a START pulse the data line is high at the strobe's rising (leading) edge and low at its falling (trailing) edge. The frame then carries these fields, with no acknowledge bit anywhere:

- a 12-bit register address,
- a one-bit command,
- an 8-bit data field.

An ABORT pulse cancels the frame at any point. In an ABORT pulse the data line is low at the leading edge and high at the trailing edge.

A write is committed only after two extra strobe pulses follow the last data bit. The commit appears as a one-clock write pulse with its address and data on the outputs. A read shifts the addressed register out on the serial output.

Top module: `ssp_slave`

## Requirements
- R1: A strobe pulse with the data input high at the rising edge and low at the falling edge is a START. The next strobe pulse carries address bit 0.
- R2: A strobe pulse with the data input low at the rising edge and high at the falling edge is an ABORT. It drops the current frame and returns the block to waiting for START, with `ser_do` low.
- R3: The address is 12 bits, sent least significant bit first. It is followed by one command bit, where 1 means write and 0 means read.
- R4: Write data is 8 bits, sent bit 0 first. The write commits after the falling edge of the second extra strobe pulse that follows data bit 7. The commit is exactly one clock of `reg_we`, with `reg_waddr` and `reg_wdata` valid, and the register then holds the new value.
- R5: A write that is aborted, or that does not receive both extra strobe pulses before the next START, never changes the register file and raises no `reg_we`.
- R6: On a read, bit k of the addressed register appears on `ser_do` after the falling edge of the strobe pulse that comes before data pulse k. It stays valid through that pulse's rising edge. `ser_do` is low again after the eighth data pulse falls.
- R7: A START received in the middle of a frame discards the partial frame and starts a new address field.
- R8: After reset every register reads 0, `ser_do` is low and `reg_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_di | input | 1 | Serial data from the host |
| ser_stb | input | 1 | Shift strobe from the host, idle low |
| ser_do | output | 1 | Serial read-back data |
| reg_we | output | 1 | One-clock write commit pulse |
| reg_waddr | output | 12 | Address of the committed write |
| reg_wdata | output | 8 | Data of the committed write |

## Verification
Every strobe edge passes through two synchronizer flops and one edge-detect flop before the frame logic registers its result. So `ser_do` and `reg_we` respond three system clocks after the falling edge of the strobe that causes them. The bench holds each strobe level and each data setup for six clocks, which is twice that latency. It samples `ser_do` on the falling clock edge just before it raises the strobe for the bit being read. Commit pulses are counted by a monitor on the falling clock edge, and the count and the last write address and data are compared once the frame's last strobe has settled.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 8;
    localparam int TAIL_CLKS = 2;
    localparam int CNT_W     = $clog2(ADDR_W);

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_CMD, ST_DATA, ST_TAIL
    } frame_st_e;

    typedef enum logic [1:0] {
        EV_NONE, EV_BIT, EV_START, EV_ABORT
    } pulse_kind_e;

    typedef struct packed {
        pulse_kind_e kind;
        logic        val;
    } pulse_evt_t;

    // classify a strobe pulse from the data level at its two edges
    function automatic pulse_kind_e classify(logic lead_lvl, logic trail_lvl);
        if (lead_lvl && !trail_lvl)
            return EV_START;
        else if (!lead_lvl && trail_lvl)
            return EV_ABORT;
        else
            return EV_BIT;
    endfunction
endpackage

// File: rtl/ssp_sync_edge.sv
module ssp_sync_edge
    import ssp_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       di,
    input  logic       stb,
    output pulse_evt_t evt
);
    localparam int NSIG = 2;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] chain [STAGES];
    logic            di_s, stb_s, stb_prev, lead_lvl;

    assign raw = {stb, di};

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[g] <= '0;
                else if (g == 0)
                    chain[g] <= raw;
                else
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign di_s  = chain[STAGES-1][0];
    assign stb_s = chain[STAGES-1][1];

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_prev <= 1'b0;
            lead_lvl <= 1'b0;
        end else begin
            stb_prev <= stb_s;
            if (stb_s && !stb_prev)
                lead_lvl <= di_s;
        end
    end

    always_comb begin
        evt = '{kind: EV_NONE, val: di_s};
        if (!stb_s && stb_prev)
            evt.kind = classify(lead_lvl, di_s);
    end

    // R1: a strobe pulse yields one event only
    a_r1_single_event: assert property (@(posedge clk) disable iff (rst)
        (evt.kind != EV_NONE) |=> (evt.kind == EV_NONE));
endmodule

// File: rtl/ssp_frame_fsm.sv
module ssp_frame_fsm
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pulse_evt_t        evt,
    input  logic [DATA_W-1:0] rd_byte,
    output logic [ADDR_W-1:0] addr_q,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              ser_do
);
    frame_st_e         state;
    logic [CNT_W-1:0]  cnt;
    logic              is_wr;
    logic [DATA_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            is_wr   <= 1'b0;
            addr_q  <= '0;
            shreg   <= '0;
            ser_do  <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            unique case (evt.kind)
                EV_START: begin
                    state  <= ST_ADDR;
                    cnt    <= '0;
                    ser_do <= 1'b0;
                end
                EV_ABORT: begin
                    state  <= ST_IDLE;
                    ser_do <= 1'b0;
                end
                EV_BIT: begin
                    unique case (state)
                        ST_ADDR: begin
                            addr_q[cnt] <= evt.val;
                            if (cnt == CNT_W'(ADDR_W-1))
                                state <= ST_CMD;
                            else
                                cnt <= cnt + 1'b1;
                        end
                        ST_CMD: begin
                            is_wr <= evt.val;
                            cnt   <= '0;
                            state <= ST_DATA;
                            if (!evt.val) begin
                                ser_do <= rd_byte[0];
                                shreg  <= rd_byte >> 1;
                            end
                        end
                        ST_DATA: begin
                            if (is_wr) begin
                                shreg[cnt] <= evt.val;
                            end else begin
                                ser_do <= shreg[0];
                                shreg  <= shreg >> 1;
                            end
                            if (cnt == CNT_W'(DATA_W-1)) begin
                                cnt <= '0;
                                if (is_wr) begin
                                    state <= ST_TAIL;
                                end else begin
                                    state  <= ST_IDLE;
                                    ser_do <= 1'b0;
                                end
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        ST_TAIL: begin
                            if (cnt == CNT_W'(TAIL_CLKS-1)) begin
                                state   <= ST_IDLE;
                                wr_en   <= 1'b1;
                                wr_addr <= addr_q;
                                wr_data <= shreg;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // R1: START always opens the address field
    a_r1_start_to_addr: assert property (@(posedge clk) disable iff (rst)
        (evt.kind == EV_START) |=> (state == ST_ADDR && cnt == '0));
    // R2: ABORT returns to idle with the output low
    a_r2_abort_idle: assert property (@(posedge clk) disable iff (rst)
        (evt.kind == EV_ABORT) |=> (state == ST_IDLE && !ser_do));
    // R4: commit pulse lasts one clock
    a_r4_one_clock_we: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);
    // R5: commit only leaves the tail phase
    a_r5_commit_from_tail: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ($past(state) == ST_TAIL && state == ST_IDLE));
    // R6: no read-back drive while idle
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !ser_do);
endmodule

// File: rtl/ssp_regfile.sv
module ssp_regfile
    import ssp_pkg::*;
#(
    parameter int DEPTH = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (we) begin
            mem[waddr[IDX_W-1:0]] <= wdata;
        end
    end

    assign rdata = mem[raddr[IDX_W-1:0]];

    // R4: a commit lands in storage on the next clock
    a_r4_store: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(waddr[IDX_W-1:0])] == $past(wdata)));
endmodule

// File: rtl/ssp_slave.sv
module ssp_slave
    import ssp_pkg::*;
#(
    parameter int DEPTH       = 4096,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_di,
    input  logic              ser_stb,
    output logic              ser_do,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_waddr,
    output logic [DATA_W-1:0] reg_wdata
);
    pulse_evt_t        evt;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] rd_byte;

    ssp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .di  (ser_di),
        .stb (ser_stb),
        .evt (evt)
    );

    ssp_frame_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .rd_byte (rd_byte),
        .addr_q  (addr_q),
        .wr_en   (reg_we),
        .wr_addr (reg_waddr),
        .wr_data (reg_wdata),
        .ser_do  (ser_do)
    );

    ssp_regfile #(.DEPTH(DEPTH)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .waddr (reg_waddr),
        .wdata (reg_wdata),
        .raddr (addr_q),
        .rdata (rd_byte)
    );
endmodule

// File: tb/test_ssp_slave.sv
module test_ssp_slave;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 6;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_di = 1'b0;
    logic        ser_stb = 1'b0;
    logic        ser_do, reg_we;
    logic [11:0] reg_waddr;
    logic [7:0]  reg_wdata;

    int compared = 0, mismatched = 0;
    int we_cnt = 0;
    logic [11:0] last_a = '0;
    logic [7:0]  last_d = '0;
    logic [7:0]  model [4096];

    always #(CLK_PERIOD/2) clk = ~clk;

    ssp_slave i_ssp_slave (
        .clk(clk), .rst(rst), .ser_di(ser_di), .ser_stb(ser_stb),
        .ser_do(ser_do), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata)
    );

    always @(negedge clk) if (!rst && reg_we) begin
        we_cnt++;
        last_a = reg_waddr;
        last_d = reg_wdata;
    end

    task automatic chk(string req, int act, int exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_h();
        repeat (H) @(negedge clk);
    endtask

    task automatic pulse(logic lead, logic trail);
        ser_di = lead;  wait_h();
        ser_stb = 1'b1; wait_h();
        ser_di = trail; wait_h();
        ser_stb = 1'b0; wait_h();
    endtask

    task automatic send_bit(logic b); pulse(b, b); endtask
    task automatic send_start(); pulse(1'b1, 1'b0); endtask
    task automatic send_abort(); pulse(1'b0, 1'b1); endtask

    task automatic head(logic [11:0] a, logic cmd);
        send_start();
        for (int i = 0; i < 12; i++) send_bit(a[i]);
        send_bit(cmd);
    endtask

    task automatic do_write(logic [11:0] a, logic [7:0] d);
        head(a, 1'b1);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        send_bit(1'b0);
        send_bit(1'b0);
        wait_h();
        model[a] = d;
    endtask

    // returns the byte sampled just before each data rising edge
    task automatic do_read(logic [11:0] a, output logic [7:0] got, output logic tail_lvl);
        head(a, 1'b0);
        for (int i = 0; i < 8; i++) begin
            ser_di = 1'b0; wait_h();
            got[i] = ser_do;
            ser_stb = 1'b1; wait_h(); wait_h();
            ser_stb = 1'b0; wait_h();
        end
        wait_h();
        tail_lvl = ser_do;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [7:0]  got;
        logic        tl;
        int          n;
        logic [11:0] pool [8];
        void'($urandom(32'd1357));
        for (int i = 0; i < 4096; i++) model[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R8: reset state
        chk("R8 ser_do after reset", ser_do, 0);
        chk("R8 reg_we after reset", reg_we, 0);
        do_read(12'h5A3, got, tl);
        chk("R8 register reads zero", got, 0);

        // R3 R4: write then read back, boundary addresses
        do_write(12'h000, 8'hA5);
        chk("R4 one commit", we_cnt, 1);
        chk("R3 commit address", last_a, 12'h000);
        chk("R4 commit data", last_d, 8'hA5);
        do_write(12'hFFF, 8'h3C);
        chk("R3 commit address top", last_a, 12'hFFF);
        do_read(12'hFFF, got, tl);
        chk("R6 read top", got, 8'h3C);
        chk("R6 output low after read", tl, 0);
        do_read(12'h000, got, tl);
        chk("R6 read bottom", got, 8'hA5);

        // R2 R5: abort mid write
        n = we_cnt;
        head(12'h123, 1'b1);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        send_abort();
        chk("R2 ser_do after abort", ser_do, 0);
        chk("R5 no commit on abort", we_cnt, n);
        do_read(12'h123, got, tl);
        chk("R5 aborted write left value", got, model[12'h123]);

        // R5: only one tail pulse, then a new START
        n = we_cnt;
        head(12'h456, 1'b1);
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        send_bit(1'b0);
        do_read(12'h456, got, tl);
        chk("R5 short tail no commit", we_cnt, n);
        chk("R5 short tail value kept", got, model[12'h456]);

        // R7: START mid address restarts the frame
        send_start();
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        do_write(12'h0F0, 8'h81);
        chk("R7 restarted frame address", last_a, 12'h0F0);
        chk("R7 restarted frame data", last_d, 8'h81);

        // R2: abort during read-back
        do_write(12'h777, 8'hFF);
        head(12'h777, 1'b0);
        send_bit(1'b0); send_bit(1'b0);
        send_abort();
        chk("R2 ser_do low after read abort", ser_do, 0);

        // R1 R3 R4 R6: random traffic over a small address pool
        for (int i = 0; i < 8; i++) pool[i] = 12'($urandom);
        pool[0] = 12'h000; pool[1] = 12'hFFF;
        for (int t = 0; t < 30; t++) begin
            logic [11:0] a;
            logic [7:0]  d;
            a = pool[$urandom % 8];
            d = 8'($urandom);
            if ($urandom % 2) begin
                n = we_cnt;
                do_write(a, d);
                chk("R4 random commit count", we_cnt, n + 1);
                chk("R1 random commit address", last_a, a);
                chk("R4 random commit data", last_d, d);
            end else begin
                do_read(a, got, tl);
                chk("R6 random read", got, model[a]);
                chk("R6 random read tail", tl, 0);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule